// File: doc/BRIEF.md
# Two-Bit Branch Direction Predictor

This block keeps a table of 2-bit saturating counters that guess whether a conditional branch will be taken. A fetch-side lookup port takes a branch address and answers with a predicted direction in the same cycle. A resolve port takes the address of a branch that has executed and its real direction. It reports whether the earlier guess was wrong, how many stall cycles that costs, and whether the branch was taken, which serves as a redirect hint for later stages. On the clock edge it then moves the selected counter one step toward the real outcome.

Instructions sit on halfword boundaries, so address bit 0 carries no information. The table is indexed by address bits 1 and up, inside a window of `PC_SPAN` bytes, where `PC_SPAN` is a power of two. This gives `PC_SPAN/2` counters.

After reset the block walks through the table and clears one counter per cycle. It raises `busy` while it does so, and during that time it accepts no updates and predicts not-taken.

Top module: `bp_two_bit_table`

## Requirements
- R1: After `rst_n` is released, `busy` stays high for exactly `PC_SPAN/2 + 2` rising clock edges and then stays low. Once it is low, every counter reads 0, so every lookup predicts not-taken. While `busy` is high, `lk_taken` is 0.
- R2: The counter index is address bits `[log2(PC_SPAN)-1:1]`. Bit 0 and all bits at or above `log2(PC_SPAN)` have no effect on which counter is used.
- R3: `lk_taken` is 1 exactly when bit 1 of the indexed counter is 1, which means a counter value of 2 or 3.
- R4: A taken resolve adds one to the indexed counter. A counter already at 3 stays at 3.
- R5: A not-taken resolve subtracts one from the indexed counter. A counter already at 0 stays at 0.
- R6: During a resolve, `rs_mispredict` is 1 when `rs_taken` differs from bit 1 of the counter before the update. `rs_penalty` is `MISS_PENALTY` (default 2) on a miss and 0 otherwise.
- R7: `rs_jump` is 1 during a resolve exactly when `rs_taken` is 1.
- R8: A lookup and a resolve to the same counter in the same cycle give a prediction from the value before the update. The new value is visible from the next cycle.
- R9: While `busy` is high, resolves are ignored: `rs_mispredict`, `rs_penalty` and `rs_jump` stay 0, and no counter is changed.
- R10: A resolve changes only the counter it indexes. All other counters keep their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| lk_pc | input | PC_W | Address of the branch being predicted |
| lk_taken | output | 1 | Predicted direction, 1 means taken |
| rs_valid | input | 1 | A resolved branch is presented this cycle |
| rs_pc | input | PC_W | Address of the resolved branch |
| rs_taken | input | 1 | Actual direction of the resolved branch |
| rs_mispredict | output | 1 | The stored guess disagreed with the outcome |
| rs_penalty | output | PEN_W | Stall cycles caused by this resolve |
| rs_jump | output | 1 | The resolved branch was taken |
| busy | output | 1 | The counter table is being cleared after reset |

## Verification
The counter-step assertions assume that an update reaches the table only when `rs_valid` is high and `busy` is low. They also assume that resolve inputs are stable around the clock edge. The stimulus meets both conditions: it changes inputs only on falling edges and lowers `rs_valid` before any lookup-only cycle. The idle-while-clearing property needs resolves to arrive during the clear walk. So one scenario drives a taken resolve into the same counter on every cycle while `busy` is high. This gives an ignored resolve the chance to leave a visible taken prediction behind.

// File: rtl/bp_pkg.sv
package bp_pkg;
  typedef logic [1:0] ctr_t;

  localparam ctr_t CTR_LO = 2'd0;
  localparam ctr_t CTR_HI = 2'd3;

  // One saturating step toward the observed direction.
  function automatic ctr_t ctr_step(input ctr_t cur, input logic taken);
    ctr_t nxt;
    nxt = cur;
    if (taken && cur != CTR_HI) nxt = cur + 2'd1;
    else if (!taken && cur != CTR_LO) nxt = cur - 2'd1;
    return nxt;
  endfunction

  function automatic logic ctr_dir(input ctr_t cur);
    return cur[1];
  endfunction
endpackage

// File: rtl/bp_rst_sync.sv
module bp_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= 2'b00;
    else         sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_o = sync_q[1];
endmodule

// File: rtl/bp_clear_seq.sv
module bp_clear_seq #(
  parameter int DEPTH = 16,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  output logic             busy_o,
  output logic [IDX_W-1:0] clr_idx_o
);
  logic             busy_q, busy_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic             last;

  assign last = (idx_q == IDX_W'(DEPTH - 1));

  always_comb begin
    busy_d = busy_q;
    idx_d  = idx_q;
    if (busy_q) begin
      idx_d = idx_q + IDX_W'(1);
      if (last) busy_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b1;
      idx_q  <= '0;
    end else if (busy_q) begin
      busy_q <= busy_d;
      idx_q  <= idx_d;
    end
  end

  assign busy_o    = busy_q;
  assign clr_idx_o = idx_q;

  // R1: the walk runs once per reset and never restarts on its own.
  p_busy_stays_low_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_q |=> !busy_q);
endmodule

// File: rtl/bp_ctr_table.sv
module bp_ctr_table
  import bp_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_en,
  input  logic [IDX_W-1:0] clr_idx,
  input  logic             upd_en,
  input  logic [IDX_W-1:0] upd_idx,
  input  logic             upd_taken,
  input  logic [IDX_W-1:0] lk_idx,
  output ctr_t             lk_ctr,
  output ctr_t             upd_ctr
);
  ctr_t             ctr_q [DEPTH];
  logic [DEPTH-1:0] wr_sel;
  ctr_t             wr_val;

  assign upd_ctr = ctr_q[upd_idx];
  assign lk_ctr  = ctr_q[lk_idx];
  assign wr_val  = clr_en ? CTR_LO : ctr_step(upd_ctr, upd_taken);

  for (genvar g = 0; g < DEPTH; g++) begin : g_sel
    assign wr_sel[g] = (clr_en && clr_idx == IDX_W'(g)) ||
                       (!clr_en && upd_en && upd_idx == IDX_W'(g));
  end

  // Storage carries no reset; the clear sequencer zeroes it.
  always_ff @(posedge clk) begin
    for (int i = 0; i < DEPTH; i++) begin
      if (wr_sel[i]) ctr_q[i] <= wr_val;
    end
  end

  p_taken_steps_up_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_en && !clr_en && upd_taken && upd_ctr != CTR_HI)
      |=> ctr_q[$past(upd_idx)] == $past(upd_ctr) + 2'd1);
  p_taken_saturates_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_en && !clr_en && upd_taken && upd_ctr == CTR_HI)
      |=> ctr_q[$past(upd_idx)] == CTR_HI);
  p_nt_steps_down_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_en && !clr_en && !upd_taken && upd_ctr != CTR_LO)
      |=> ctr_q[$past(upd_idx)] == $past(upd_ctr) - 2'd1);
  p_nt_saturates_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_en && !clr_en && !upd_taken && upd_ctr == CTR_LO)
      |=> ctr_q[$past(upd_idx)] == CTR_LO);
endmodule

// File: rtl/bp_two_bit_table.sv
module bp_two_bit_table
  import bp_pkg::*;
#(
  parameter int PC_W         = 32,
  parameter int PC_SPAN      = 32,
  parameter int MISS_PENALTY = 2,
  localparam int PEN_W = $clog2(MISS_PENALTY + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PC_W-1:0]  lk_pc,
  output logic             lk_taken,
  input  logic             rs_valid,
  input  logic [PC_W-1:0]  rs_pc,
  input  logic             rs_taken,
  output logic             rs_mispredict,
  output logic [PEN_W-1:0] rs_penalty,
  output logic             rs_jump,
  output logic             busy
);
  localparam int DEPTH = PC_SPAN / 2;
  localparam int IDX_W = $clog2(DEPTH);
  localparam int TOP_B = $clog2(PC_SPAN) - 1;

  logic             rst_int_n;
  logic             clr_busy;
  logic [IDX_W-1:0] clr_idx;
  logic [IDX_W-1:0] lk_idx, rs_idx;
  ctr_t             lk_ctr, rs_ctr;
  logic             rs_live, miss;

  bp_rst_sync u_rst_sync (
    .clk     (clk),
    .arst_n  (rst_n),
    .rst_n_o (rst_int_n)
  );

  bp_clear_seq #(.DEPTH(DEPTH)) u_clear (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .busy_o    (clr_busy),
    .clr_idx_o (clr_idx)
  );

  // Halfword-aligned code: address bit 0 is dropped from the index.
  assign lk_idx  = lk_pc[TOP_B:1];
  assign rs_idx  = rs_pc[TOP_B:1];
  assign rs_live = rs_valid && !clr_busy;

  bp_ctr_table #(.DEPTH(DEPTH)) u_table (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .clr_en    (clr_busy),
    .clr_idx   (clr_idx),
    .upd_en    (rs_live),
    .upd_idx   (rs_idx),
    .upd_taken (rs_taken),
    .lk_idx    (lk_idx),
    .lk_ctr    (lk_ctr),
    .upd_ctr   (rs_ctr)
  );

  assign miss          = rs_live && (rs_taken != ctr_dir(rs_ctr));
  assign lk_taken      = !clr_busy && ctr_dir(lk_ctr);
  assign rs_mispredict = miss;
  assign rs_penalty    = miss ? PEN_W'(MISS_PENALTY) : '0;
  assign rs_jump       = rs_live && rs_taken;
  assign busy          = clr_busy;

  p_quiet_while_clearing_r9: assert property (@(posedge clk) disable iff (!rst_int_n)
    busy |-> (!rs_mispredict && !rs_jump && rs_penalty == '0 && !lk_taken));
endmodule

// File: tb/bp_two_bit_table_bench.sv
module bp_two_bit_table_bench;
  localparam int SPAN  = 32;
  localparam int DEPTH = SPAN / 2;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [31:0] lk_pc, rs_pc;
  logic        lk_taken, rs_valid, rs_taken, rs_mispredict, rs_jump, busy;
  logic [1:0]  rs_penalty;

  int n_checks = 0;
  int n_fail   = 0;
  logic [1:0] model [DEPTH];

  always #10 clk = ~clk;

  bp_two_bit_table u_bp_two_bit_table (
    .clk(clk), .rst_n(rst_n), .lk_pc(lk_pc), .lk_taken(lk_taken),
    .rs_valid(rs_valid), .rs_pc(rs_pc), .rs_taken(rs_taken),
    .rs_mispredict(rs_mispredict), .rs_penalty(rs_penalty),
    .rs_jump(rs_jump), .busy(busy)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int idx_of(input logic [31:0] pc);
    return int'(pc[4:1]);
  endfunction

  function automatic logic [1:0] step(input logic [1:0] c, input logic t);
    if (t) return (c == 2'd3) ? c : c + 2'd1;
    return (c == 2'd0) ? c : c - 2'd1;
  endfunction

  task automatic resolve(input logic [31:0] pc, input logic t, input string req);
    int  i;
    logic miss;
    @(negedge clk);
    rs_valid = 1'b1; rs_pc = pc; rs_taken = t;
    #2;
    i    = idx_of(pc);
    miss = (t != model[i][1]);
    chk({req, "/R6"}, "mispredict", int'(rs_mispredict), int'(miss));
    chk({req, "/R6"}, "penalty", int'(rs_penalty), miss ? 2 : 0);
    chk({req, "/R7"}, "jump", int'(rs_jump), int'(t));
    model[i] = step(model[i], t);
  endtask

  task automatic look(input logic [31:0] pc, input string req);
    @(negedge clk);
    rs_valid = 1'b0; lk_pc = pc;
    #2;
    chk({req, "/R3"}, "lk_taken", int'(lk_taken), int'(model[idx_of(pc)][1]));
  endtask

  task automatic look_all(input string req);
    for (int k = 0; k < DEPTH; k++) look(32'(2 * k), req);
  endtask

  task automatic t_reset_walk;
    int edges;
    @(negedge clk); rst_n = 1'b0; rs_valid = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1; lk_pc = 32'h0; edges = 0;
    do begin
      @(posedge clk); edges++;
      @(negedge clk); #2;
      if (busy) chk("R1", "lk_taken while busy", int'(lk_taken), 0);
    end while (busy && edges < 4 * DEPTH);
    chk("R1", "busy edges", edges, DEPTH + 2);
    for (int k = 0; k < DEPTH; k++) model[k] = 2'd0;
    look_all("R1");
  endtask

  task automatic t_busy_ignore;
    @(negedge clk); rst_n = 1'b0; rs_valid = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    rs_valid = 1'b1; rs_pc = 32'h0; rs_taken = 1'b1;
    for (int c = 0; c < 4 * DEPTH; c++) begin
      @(negedge clk); #2;
      if (!busy) break;
      chk("R9", "jump while busy", int'(rs_jump), 0);
      chk("R9", "mispredict while busy", int'(rs_mispredict), 0);
      chk("R9", "penalty while busy", int'(rs_penalty), 0);
    end
    rs_valid = 1'b0;
    for (int k = 0; k < DEPTH; k++) model[k] = 2'd0;
    look_all("R9");
  endtask

  task automatic t_sat_up;
    for (int n = 0; n < 5; n++) resolve(32'h06, 1'b1, "R4");
    look(32'h06, "R4");
    resolve(32'h06, 1'b0, "R4");
    look(32'h06, "R4 saturated at 3 then one down");
    resolve(32'h06, 1'b0, "R4");
    look(32'h06, "R4");
  endtask

  task automatic t_sat_down;
    for (int n = 0; n < 4; n++) resolve(32'h0A, 1'b0, "R5");
    resolve(32'h0A, 1'b1, "R5");
    look(32'h0A, "R5 floor held");
    resolve(32'h0A, 1'b1, "R5");
    look(32'h0A, "R5");
  endtask

  task automatic t_alias;
    resolve(32'h10, 1'b1, "R2");
    resolve(32'h10, 1'b1, "R2");
    look(32'h11, "R2 bit0");
    look(32'h30, "R2 above span");
    look(32'h1234_5670, "R2 high bits");
    resolve(32'h0000_0071, 1'b0, "R2 alias resolve");
    look(32'h10, "R2");
  endtask

  task automatic t_bypass;
    resolve(32'h18, 1'b1, "R8 setup");
    @(negedge clk);
    rs_valid = 1'b1; rs_pc = 32'h18; rs_taken = 1'b1; lk_pc = 32'h18;
    #2;
    chk("R8", "same-cycle lookup", int'(lk_taken), 0);
    model[12] = step(model[12], 1'b1);
    look(32'h18, "R8 next cycle");
  endtask

  task automatic t_indep;
    look_all("R10");
  endtask

  initial begin
    rst_n = 1'b0; rs_valid = 1'b0; rs_pc = '0; rs_taken = 1'b0; lk_pc = '0;
    t_reset_walk();
    t_sat_up();
    t_sat_down();
    t_alias();
    t_bypass();
    t_indep();
    t_busy_ignore();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule